// File: doc/BRIEF.md
# Domain-Tagged Device Translation Cache

This block is a small, fully associative cache of address translations for DMA issued by devices. Each entry binds a device page number, within one protection domain, to a host physical page number. It also carries a read permission and a write permission. Every device access presents its domain, page and direction on the lookup port. In the same cycle the block answers with a hit and the translated page, a permission fault, or a miss. On a miss, an external page-table walker supplies the translation through the fill port.

The hardware never compares cached entries against the page table in memory. A mapping that software removes from the table stays usable here until software sends an explicit invalidation. The invalidation port has a valid/ready handshake and returns a one-cycle completion pulse. It accepts two kinds of command. A selective command drops the entries of one domain whose page falls inside a naturally aligned block of 2^order pages. A global command drops every entry.

Top module: `iotlb_dom`

## Requirements
- R1: When `lk_valid` is high and a valid entry matches both `lk_dom` and `lk_vpn` with sufficient permission, `lk_hit` is high and `lk_ppn` carries that entry's physical page in the same cycle.
- R2: A read (`lk_write`=0) needs the entry's read permission and a write (`lk_write`=1) needs its write permission. A matching lookup without that permission raises `lk_fault`, keeps `lk_hit` low and drives `lk_ppn` to zero.
- R3: With `lk_valid` high, exactly one of `lk_hit`, `lk_miss`, `lk_fault` is high. `lk_miss` means no valid entry matched, and `lk_ppn` is then zero. With `lk_valid` low, all three are low.
- R4: A lookup matches only an entry with the same domain. The same page in another domain misses.
- R5: A fill presented with `fl_valid` at a clock edge can be looked up from the next cycle on. A fill whose domain and page are already cached overwrites that entry in place.
- R6: Cached entries stay usable for any number of cycles until an invalidation removes them. Nothing else ages or drops them.
- R7: An accepted selective invalidation (`iv_global`=0) removes every entry of domain `iv_dom` whose page agrees with `iv_vpn` in all bits from position `iv_order` upward. The low `iv_order` bits of `iv_vpn` are ignored.
- R8: A selective invalidation leaves untouched the entries of other domains and the entries of the same domain outside its range.
- R9: An accepted global invalidation (`iv_global`=1) removes every entry of every domain.
- R10: `iv_ready` is high except in the cycle after an acceptance. A command is accepted at an edge where `iv_valid` and `iv_ready` are both high, and `iv_done` is high for exactly the following cycle.
- R11: A lookup in the same cycle as an accepted invalidation that covers the matching entry reports a miss.
- R12: A fill that is not already cached goes into the first invalid entry found by scanning from a rotating pointer. It goes into the pointer's own entry only when all entries are valid. After each such fill the pointer moves one past the chosen entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all entries invalid |
| lk_valid | input | 1 | Lookup request |
| lk_dom | input | DOM_W | Lookup protection domain |
| lk_vpn | input | VPN_W | Lookup device page number |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_hit | output | 1 | Translation found with permission |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry lacks permission |
| lk_ppn | output | PPN_W | Host physical page on hit, zero otherwise |
| fl_valid | input | 1 | Fill strobe from the walker |
| fl_dom | input | DOM_W | Fill domain |
| fl_vpn | input | VPN_W | Fill device page |
| fl_ppn | input | PPN_W | Fill physical page |
| fl_rd | input | 1 | Fill read permission |
| fl_wr | input | 1 | Fill write permission |
| iv_valid | input | 1 | Invalidation request |
| iv_ready | output | 1 | Invalidation can be accepted |
| iv_global | input | 1 | 1 = flush all, 0 = selective |
| iv_dom | input | DOM_W | Selective invalidation domain |
| iv_vpn | input | VPN_W | Selective invalidation base page |
| iv_order | input | ORD_W | log2 of pages in the selective range |
| iv_done | output | 1 | One-cycle completion pulse |

## Verification
A lookup and an invalidation can both happen in one cycle, and the lookup may target the very entry being removed. The bench caches a page and then drives a selective invalidation of that page together with a lookup of it in the same cycle. It checks that the lookup already reports a miss. It then finishes the handshake and confirms that the miss persists. The checker also asserts that no lookup can hit in a cycle when a global flush is accepted.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

   typedef enum logic [1:0] {
      LK_MISS  = 2'd0,
      LK_HIT   = 2'd1,
      LK_FAULT = 2'd2
   } lk_res_e;

   function automatic logic perm_ok(input logic is_wr, input logic may_rd, input logic may_wr);
      return is_wr ? may_wr : may_rd;
   endfunction

endpackage

// File: rtl/iotlb_cam.sv
module iotlb_cam #(
   parameter int N_ENT = 16,
   parameter int DOM_W = 4,
   parameter int VPN_W = 20,
   parameter int ORD_W = 5
) (
   input  logic [N_ENT-1:0][DOM_W-1:0] ent_dom,
   input  logic [N_ENT-1:0][VPN_W-1:0] ent_vpn,
   input  logic [DOM_W-1:0]            lk_dom,
   input  logic [VPN_W-1:0]            lk_vpn,
   input  logic [DOM_W-1:0]            fl_dom,
   input  logic [VPN_W-1:0]            fl_vpn,
   input  logic                        iv_global,
   input  logic [DOM_W-1:0]            iv_dom,
   input  logic [VPN_W-1:0]            iv_vpn,
   input  logic [ORD_W-1:0]            iv_order,
   output logic [N_ENT-1:0]            lk_match,
   output logic [N_ENT-1:0]            fl_match,
   output logic [N_ENT-1:0]            iv_match
);

   logic [VPN_W-1:0] keep_mask;

   // bits below the order are don't-care within the aligned block
   assign keep_mask = ~((VPN_W'(1) << iv_order) - VPN_W'(1));

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      assign lk_match[i] = (ent_dom[i] == lk_dom) && (ent_vpn[i] == lk_vpn);
      assign fl_match[i] = (ent_dom[i] == fl_dom) && (ent_vpn[i] == fl_vpn);
      assign iv_match[i] = iv_global ||
                           ((ent_dom[i] == iv_dom) &&
                            (((ent_vpn[i] ^ iv_vpn) & keep_mask) == '0));
   end

endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
   parameter int N_ENT = 16,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic [N_ENT-1:0] ent_vld,
   input  logic [IDX_W-1:0] rr_ptr,
   output logic [IDX_W-1:0] victim
);

   logic             found;
   logic [IDX_W-1:0] probe;

   always_comb begin
      victim = rr_ptr;
      found  = 1'b0;
      probe  = rr_ptr;
      for (int k = 0; k < N_ENT; k++) begin
         probe = rr_ptr + IDX_W'(k);
         if (!found && !ent_vld[probe]) begin
            victim = probe;
            found  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/iotlb_dom.sv
module iotlb_dom #(
   parameter int N_ENT = 16,
   parameter int DOM_W = 4,
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   localparam int IDX_W = $clog2(N_ENT),
   localparam int ORD_W = $clog2(VPN_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [DOM_W-1:0] lk_dom,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic             lk_write,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic             lk_fault,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             fl_valid,
   input  logic [DOM_W-1:0] fl_dom,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [PPN_W-1:0] fl_ppn,
   input  logic             fl_rd,
   input  logic             fl_wr,
   input  logic             iv_valid,
   output logic             iv_ready,
   input  logic             iv_global,
   input  logic [DOM_W-1:0] iv_dom,
   input  logic [VPN_W-1:0] iv_vpn,
   input  logic [ORD_W-1:0] iv_order,
   output logic             iv_done
);
   import iotlb_pkg::*;

   if (N_ENT < 2 || (N_ENT & (N_ENT - 1)) != 0) begin : g_bad_depth
      $error("iotlb_dom: N_ENT must be a power of two of at least 2");
   end
   if (DOM_W < 1 || VPN_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("iotlb_dom: field widths must be positive");
   end

   logic [N_ENT-1:0]            ent_vld_q;
   logic [N_ENT-1:0][DOM_W-1:0] ent_dom_q;
   logic [N_ENT-1:0][VPN_W-1:0] ent_vpn_q;
   logic [N_ENT-1:0][PPN_W-1:0] ent_ppn_q;
   logic [N_ENT-1:0]            ent_rd_q;
   logic [N_ENT-1:0]            ent_wr_q;
   logic [IDX_W-1:0]            rr_q;
   logic                        done_q;

   logic [N_ENT-1:0] lk_match, fl_match, iv_match;
   logic [N_ENT-1:0] iv_kill, lk_live, fl_live;
   logic             iv_acc;
   logic [IDX_W-1:0] victim, fill_idx;
   logic             fl_dup;
   logic             sel_any, sel_rd, sel_wr;
   logic [PPN_W-1:0] sel_ppn;
   lk_res_e          res;

   iotlb_cam #(
      .N_ENT(N_ENT), .DOM_W(DOM_W), .VPN_W(VPN_W), .ORD_W(ORD_W)
   ) u_cam (
      .ent_dom  (ent_dom_q),
      .ent_vpn  (ent_vpn_q),
      .lk_dom   (lk_dom),
      .lk_vpn   (lk_vpn),
      .fl_dom   (fl_dom),
      .fl_vpn   (fl_vpn),
      .iv_global(iv_global),
      .iv_dom   (iv_dom),
      .iv_vpn   (iv_vpn),
      .iv_order (iv_order),
      .lk_match (lk_match),
      .fl_match (fl_match),
      .iv_match (iv_match)
   );

   iotlb_victim #(.N_ENT(N_ENT)) u_victim (
      .ent_vld(ent_vld_q),
      .rr_ptr (rr_q),
      .victim (victim)
   );

   assign iv_ready = !done_q;
   assign iv_done  = done_q;
   assign iv_acc   = iv_valid && iv_ready;
   assign iv_kill  = iv_acc ? iv_match : '0;
   assign lk_live  = lk_match & ent_vld_q & ~iv_kill;
   assign fl_live  = fl_match & ent_vld_q;

   // single-match read mux
   always_comb begin
      sel_any  = 1'b0;
      sel_rd   = 1'b0;
      sel_wr   = 1'b0;
      sel_ppn  = '0;
      fl_dup   = 1'b0;
      fill_idx = victim;
      for (int i = 0; i < N_ENT; i++) begin
         if (lk_live[i]) begin
            sel_any = 1'b1;
            sel_rd  = ent_rd_q[i];
            sel_wr  = ent_wr_q[i];
            sel_ppn = ent_ppn_q[i];
         end
         if (fl_live[i]) begin
            fl_dup   = 1'b1;
            fill_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (!sel_any)                          res = LK_MISS;
      else if (perm_ok(lk_write, sel_rd, sel_wr)) res = LK_HIT;
      else                                   res = LK_FAULT;
   end

   assign lk_hit   = lk_valid && (res == LK_HIT);
   assign lk_miss  = lk_valid && (res == LK_MISS);
   assign lk_fault = lk_valid && (res == LK_FAULT);
   assign lk_ppn   = lk_hit ? sel_ppn : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld_q <= '0;
         rr_q      <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= iv_acc;
         for (int i = 0; i < N_ENT; i++) begin
            if (iv_kill[i]) ent_vld_q[i] <= 1'b0;
         end
         if (fl_valid) begin
            ent_vld_q[fill_idx] <= 1'b1;
            if (!fl_dup) rr_q <= victim + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fl_valid) begin
         ent_dom_q[fill_idx] <= fl_dom;
         ent_vpn_q[fill_idx] <= fl_vpn;
         ent_ppn_q[fill_idx] <= fl_ppn;
         ent_rd_q[fill_idx]  <= fl_rd;
         ent_wr_q[fill_idx]  <= fl_wr;
      end
   end

endmodule

// File: rtl/iotlb_dom_chk.sv
module iotlb_dom_chk #(
   parameter int PPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_hit,
   input logic             lk_miss,
   input logic             lk_fault,
   input logic [PPN_W-1:0] lk_ppn,
   input logic             fl_valid,
   input logic             iv_valid,
   input logic             iv_ready,
   input logic             iv_global,
   input logic             iv_done
);

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault)); // R3
   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_fault || lk_miss) |-> lk_ppn == '0); // R2
   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && iv_ready) |=> iv_done); // R10
   AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      iv_done |-> $past(iv_valid && iv_ready)); // R10
   AST_BUSY_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      iv_done |-> !iv_ready); // R10
   AST_SAME_CYCLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && iv_valid && iv_ready && iv_global) |-> !(lk_hit || lk_fault)); // R11
   AST_GLOBAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && iv_done && $past(iv_global) && !$past(fl_valid)) |-> lk_miss); // R9

endmodule

bind iotlb_dom iotlb_dom_chk #(.PPN_W(PPN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_valid (lk_valid),
   .lk_hit   (lk_hit),
   .lk_miss  (lk_miss),
   .lk_fault (lk_fault),
   .lk_ppn   (lk_ppn),
   .fl_valid (fl_valid),
   .iv_valid (iv_valid),
   .iv_ready (iv_ready),
   .iv_global(iv_global),
   .iv_done  (iv_done)
);

// File: tb/iotlb_dom_tb_top.sv
module iotlb_dom_tb_top;

   localparam int DOM_W = 4;
   localparam int VPN_W = 20;
   localparam int PPN_W = 20;
   localparam int ORD_W = 5;
   localparam int NV    = 10;
   // {dom, vpn, write, expected code (0 miss,1 hit,2 fault), expected ppn}
   localparam logic [46:0] VEC [NV] = '{
      {4'd1, 20'h00010, 1'b0, 2'd1, 20'hAAAA0},
      {4'd1, 20'h00010, 1'b1, 2'd1, 20'hAAAA0},
      {4'd2, 20'h00010, 1'b0, 2'd1, 20'hBBBB0},
      {4'd2, 20'h00010, 1'b1, 2'd2, 20'h00000},
      {4'd1, 20'h00020, 1'b0, 2'd2, 20'h00000},
      {4'd1, 20'h00020, 1'b1, 2'd1, 20'hCCCC0},
      {4'd3, 20'h00010, 1'b0, 2'd0, 20'h00000},
      {4'd1, 20'h00011, 1'b0, 2'd0, 20'h00000},
      {4'd3, 20'h00011, 1'b1, 2'd1, 20'hDDDD0},
      {4'd0, 20'h00010, 1'b0, 2'd0, 20'h00000}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 1'b0, lk_write = 1'b0;
   logic [DOM_W-1:0] lk_dom = '0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic             lk_hit, lk_miss, lk_fault;
   logic [PPN_W-1:0] lk_ppn;
   logic             fl_valid = 1'b0, fl_rd = 1'b0, fl_wr = 1'b0;
   logic [DOM_W-1:0] fl_dom = '0;
   logic [VPN_W-1:0] fl_vpn = '0;
   logic [PPN_W-1:0] fl_ppn = '0;
   logic             iv_valid = 1'b0, iv_global = 1'b0;
   logic [DOM_W-1:0] iv_dom = '0;
   logic [VPN_W-1:0] iv_vpn = '0;
   logic [ORD_W-1:0] iv_order = '0;
   logic             iv_ready, iv_done;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   iotlb_dom #(.N_ENT(16), .DOM_W(DOM_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_dom(lk_dom), .lk_vpn(lk_vpn), .lk_write(lk_write),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_ppn(lk_ppn),
      .fl_valid(fl_valid), .fl_dom(fl_dom), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
      .fl_rd(fl_rd), .fl_wr(fl_wr),
      .iv_valid(iv_valid), .iv_ready(iv_ready), .iv_global(iv_global),
      .iv_dom(iv_dom), .iv_vpn(iv_vpn), .iv_order(iv_order), .iv_done(iv_done)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [21:0] observed();
      logic [1:0] code;
      code = lk_fault ? 2'd2 : (lk_hit ? 2'd1 : 2'd0);
      if (!(lk_hit || lk_miss || lk_fault)) code = 2'd3;
      return {code, lk_ppn};
   endfunction

   // starts and ends on a falling edge
   task automatic lookup(input string req, input logic [3:0] d, input logic [19:0] v,
                         input logic w, input logic [1:0] code, input logic [19:0] p);
      lk_valid = 1'b1; lk_dom = d; lk_vpn = v; lk_write = w;
      #1;
      check(req, 32'(observed()), 32'({code, p}));
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [3:0] d, input logic [19:0] v, input logic [19:0] p,
                       input logic r, input logic w);
      fl_valid = 1'b1; fl_dom = d; fl_vpn = v; fl_ppn = p; fl_rd = r; fl_wr = w;
      @(negedge clk);
      fl_valid = 1'b0;
   endtask

   task automatic inval(input logic g, input logic [3:0] d, input logic [19:0] v,
                        input logic [4:0] ord);
      iv_valid = 1'b1; iv_global = g; iv_dom = d; iv_vpn = v; iv_order = ord;
      #1;
      check("R10 ready before accept", 32'(iv_ready), 32'd1);
      @(negedge clk);
      iv_valid = 1'b0;
      check("R10 done pulse", 32'(iv_done), 32'd1);
      check("R10 not ready during done", 32'(iv_ready), 32'd0);
      @(negedge clk);
      check("R10 done single cycle", 32'(iv_done), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R10 reset ready", 32'(iv_ready), 32'd1);
      check("R10 reset done", 32'(iv_done), 32'd0);
      check("R3 idle outputs", 32'(observed()), 32'({2'd3, 20'h0}));
      lookup("R3 empty after reset", 4'd1, 20'h00010, 1'b0, 2'd0, 20'h0);

      // table walk
      fill(4'd1, 20'h00010, 20'hAAAA0, 1'b1, 1'b1);
      fill(4'd2, 20'h00010, 20'hBBBB0, 1'b1, 1'b0);
      fill(4'd1, 20'h00020, 20'hCCCC0, 1'b0, 1'b1);
      fill(4'd3, 20'h00011, 20'hDDDD0, 1'b1, 1'b1);
      for (int i = 0; i < NV; i++) begin
         lookup("R1/R2/R4 vector", VEC[i][46:43], VEC[i][42:23], VEC[i][22],
                VEC[i][21:20], VEC[i][19:0]);
      end

      // R6: no ageing
      repeat (40) @(negedge clk);
      lookup("R6 entry persists", 4'd1, 20'h00010, 1'b0, 2'd1, 20'hAAAA0);

      // R5: refill in place with new permission and page
      fill(4'd1, 20'h00010, 20'h12345, 1'b1, 1'b0);
      lookup("R5 refill new page", 4'd1, 20'h00010, 1'b0, 2'd1, 20'h12345);
      lookup("R5 refill new perm", 4'd1, 20'h00010, 1'b1, 2'd2, 20'h0);

      // R7/R8 selective range: base 0x105, order 2 covers 0x104..0x107
      for (int k = 0; k < 9; k++) fill(4'd1, 20'h00100 + 20'(k), 20'h50000 + 20'(k), 1'b1, 1'b1);
      fill(4'd2, 20'h00104, 20'h60004, 1'b1, 1'b1);
      inval(1'b0, 4'd1, 20'h00105, 5'd2);
      lookup("R8 below range kept", 4'd1, 20'h00103, 1'b0, 2'd1, 20'h50003);
      lookup("R7 range start removed", 4'd1, 20'h00104, 1'b0, 2'd0, 20'h0);
      lookup("R7 range end removed", 4'd1, 20'h00107, 1'b0, 2'd0, 20'h0);
      lookup("R8 above range kept", 4'd1, 20'h00108, 1'b0, 2'd1, 20'h50008);
      lookup("R8 other domain kept", 4'd2, 20'h00104, 1'b0, 2'd1, 20'h60004);
      lookup("R8 far page kept", 4'd1, 20'h00010, 1'b0, 2'd1, 20'h12345);

      // R11: lookup in the cycle the covering invalidation is accepted
      fill(4'd5, 20'h00040, 20'h77770, 1'b1, 1'b1);
      lookup("R11 before", 4'd5, 20'h00040, 1'b0, 2'd1, 20'h77770);
      iv_valid = 1'b1; iv_global = 1'b0; iv_dom = 4'd5; iv_vpn = 20'h00040; iv_order = 5'd0;
      lk_valid = 1'b1; lk_dom = 4'd5; lk_vpn = 20'h00040; lk_write = 1'b0;
      #1;
      check("R11 same cycle miss", 32'(observed()), 32'({2'd0, 20'h0}));
      @(negedge clk);
      iv_valid = 1'b0; lk_valid = 1'b0;
      check("R10 done after same-cycle", 32'(iv_done), 32'd1);
      @(negedge clk);
      lookup("R11 stays removed", 4'd5, 20'h00040, 1'b0, 2'd0, 20'h0);

      // R9 global
      inval(1'b1, 4'd0, 20'h0, 5'd0);
      lookup("R9 dom1 gone", 4'd1, 20'h00010, 1'b0, 2'd0, 20'h0);
      lookup("R9 dom2 gone", 4'd2, 20'h00010, 1'b0, 2'd0, 20'h0);
      lookup("R9 dom2 range gone", 4'd2, 20'h00104, 1'b0, 2'd0, 20'h0);

      // R12 replacement
      for (int k = 0; k < 16; k++) fill(4'd7, 20'h00200 + 20'(k), 20'h80000 + 20'(k), 1'b1, 1'b1);
      lookup("R12 all sixteen resident", 4'd7, 20'h0020F, 1'b0, 2'd1, 20'h8000F);
      fill(4'd7, 20'h00300, 20'h90000, 1'b1, 1'b1);
      lookup("R12 oldest evicted when full", 4'd7, 20'h00200, 1'b0, 2'd0, 20'h0);
      lookup("R12 new fill present", 4'd7, 20'h00300, 1'b0, 2'd1, 20'h90000);
      inval(1'b0, 4'd7, 20'h00204, 5'd0);
      fill(4'd7, 20'h00301, 20'h90001, 1'b1, 1'b1);
      lookup("R12 invalid slot reused", 4'd7, 20'h00201, 1'b0, 2'd1, 20'h80001);
      lookup("R12 second fill present", 4'd7, 20'h00301, 1'b0, 2'd1, 20'h90001);
      lookup("R12 others untouched", 4'd7, 20'h00205, 1'b0, 2'd1, 20'h80005);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule